// File: doc/BRIEF.md
# Accumulator Exponent and Normalization Unit

This unit inspects a 36-bit accumulator value made of a 32-bit data field (bits 31..0) and four guard bits above it. It measures how many bits below the sign bit merely repeat the sign. From that count it derives a signed exponent, taken relative to bit 31 rather than to the top of the word. A value that already spills into the guard bits gets a negative exponent. A value with spare sign bits below bit 31 gets a positive one.

Two operations share the datapath. The exponent operation returns the signed exponent, sign-extended across the 36-bit result. The normalize operation shifts the source until its first significant bit sits at bit 30, just under a sign copy at bit 31. It shifts left for a positive exponent and arithmetically right for a negative one. In both operations the exponent is also presented on its own output, for storage in an auxiliary register. Each request is accepted with a valid strobe, and the answer is registered with its own strobe one clock later.

Top module: `accnorm_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R2: The exponent equals the number of bits directly below bit 35 that equal bit 35, minus 4, as a 7-bit two's complement value. Its range is -4 to 31.
- R3: When `in_op` is 0 (exponent operation), `out_result` is the exponent sign-extended to 36 bits.
- R4: When `in_op` is 1 (normalize) and the exponent is 0 to 30, `out_result` is the source shifted left by the exponent with zeros filled in. Afterwards bit 31 differs from bit 30.
- R5: When `in_op` is 1 and the exponent is negative, `out_result` is the source shifted arithmetically right by the magnitude of the exponent.
- R6: An all-zeros or all-ones source gives exponent 31. The normalize operation then returns the source unchanged.
- R7: `out_exp` carries the exponent for both operations.
- R8: After reset, `out_valid` is 0 and `out_result` and `out_exp` are 0.
- R9: In a cycle after one with `in_valid` low, `out_result` and `out_exp` keep their previous values, whatever `in_src` and `in_op` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0 = exponent, 1 = normalize |
| in_src | input | 36 | Source accumulator value |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 36 | Destination accumulator value |
| out_exp | output | 7 | Signed exponent for the auxiliary register |

## Verification
Several properties are checked on every cycle by the assertions. These are the strobe timing, the holding of outputs between requests, the exponent range and the sign-extended form of an exponent result. Another is that a left-normalized result always has bits 31 and 30 unequal. The assertions cannot tell whether a count or a shift amount is exactly right. The bench's scenarios show that with known values: a walking single bit across every position, negative and guard-bit-heavy sources, and the all-zeros and all-ones extremes.

// File: rtl/accnorm_pkg.sv
package accnorm_pkg;
    typedef enum logic {
        OP_EXP  = 1'b0,
        OP_NORM = 1'b1
    } accnorm_op_e;
endpackage

// File: rtl/accnorm_signcount.sv
module accnorm_signcount #(
    parameter int WIDTH = 36,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src,
    output logic [CNT_W-1:0] count,
    output logic             uniform
);
    logic run;

    always_comb begin
        run   = 1'b1;
        count = '0;
        for (int i = WIDTH - 2; i >= 0; i--) begin
            if (run && (src[i] == src[WIDTH-1]))
                count = count + 1'b1;
            else
                run = 1'b0;
        end
        uniform = (count == CNT_W'(WIDTH - 1));
    end
endmodule

// File: rtl/accnorm_shift.sv
module accnorm_shift #(
    parameter int WIDTH = 36,
    parameter int EXP_W = 7
) (
    input  logic [WIDTH-1:0]        src,
    input  logic signed [EXP_W-1:0] shamt,
    output logic [WIDTH-1:0]        shifted
);
    logic [EXP_W-1:0] mag;

    always_comb begin
        mag = shamt[EXP_W-1] ? (~shamt + 1'b1) : shamt;
        if (shamt[EXP_W-1])
            shifted = WIDTH'($signed(src) >>> mag);
        else
            shifted = src << mag;
    end
endmodule

// File: rtl/accnorm_unit.sv
module accnorm_unit #(
    parameter int WIDTH = 36,
    parameter int GUARD = 4,
    localparam int CNT_W = $clog2(WIDTH),
    localparam int EXP_W = CNT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_op,
    input  logic [WIDTH-1:0]        in_src,
    output logic                    out_valid,
    output logic [WIDTH-1:0]        out_result,
    output logic signed [EXP_W-1:0] out_exp
);
    import accnorm_pkg::*;

    localparam int EXP_MAX = WIDTH - 1 - GUARD;

    typedef struct packed {
        logic                    valid;
        accnorm_op_e             op;
        logic [WIDTH-1:0]        result;
        logic signed [EXP_W-1:0] expo;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0]        rsb_count;
    logic                    rsb_uniform;
    logic signed [EXP_W-1:0] exp_c;
    logic [WIDTH-1:0]        shifted_c;

    accnorm_signcount #(.WIDTH(WIDTH)) u_count (
        .src     (in_src),
        .count   (rsb_count),
        .uniform (rsb_uniform)
    );

    assign exp_c = $signed({1'b0, rsb_count}) - EXP_W'(GUARD);

    accnorm_shift #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_shift (
        .src     (in_src),
        .shamt   (exp_c),
        .shifted (shifted_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.op   = accnorm_op_e'(in_op);
            st_d.expo = exp_c;
            if (in_op == OP_EXP)
                st_d.result = {{(WIDTH-EXP_W){exp_c[EXP_W-1]}}, exp_c};
            else if (rsb_uniform)
                st_d.result = in_src;
            else
                st_d.result = shifted_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_exp    = st_q.expo;

    assert_strobe_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_exp_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_exp >= -EXP_W'(GUARD)) && (out_exp <= EXP_W'(EXP_MAX)));

    assert_exp_result_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.op == OP_EXP) |-> ($signed(out_result) == WIDTH'(out_exp)));

    assert_left_norm_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.op == OP_NORM && out_exp >= 0 && out_exp != EXP_W'(EXP_MAX))
            |-> (out_result[WIDTH-GUARD-1] != out_result[WIDTH-GUARD-2]));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_exp)));
endmodule

// File: tb/sim_accnorm_unit.sv
module sim_accnorm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [35:0] in_src = '0;
    logic        out_valid;
    logic [35:0] out_result;
    logic signed [6:0] out_exp;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    accnorm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_src(in_src), .out_valid(out_valid), .out_result(out_result),
        .out_exp(out_exp)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at following negedge
    task automatic apply(logic op, logic [35:0] src);
        @(negedge clk);
        in_op = op; in_src = src; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(string req, logic [35:0] res, int e);
        check({req, " valid R1"}, 64'(out_valid), 64'd1);
        check({req, " result"}, 64'(out_result), 64'(res));
        check({req, " exp R7"}, 64'(out_exp), 64'(7'(e)));
    endtask

    task automatic t_reset;
        check("R8 valid", 64'(out_valid), 64'd0);
        check("R8 result", 64'(out_result), 64'd0);
        check("R8 exp", 64'(out_exp), 64'd0);
    endtask

    task automatic t_exponent;
        apply(1'b0, 36'h040000000); expect_out("R2 R3 aligned", 36'h0, 0);
        apply(1'b0, 36'h000000001); expect_out("R2 R3 one", 36'd30, 30);
        apply(1'b0, 36'h800000000); expect_out("R2 R3 neg", 36'hFFFFFFFFC, -4);
        apply(1'b0, 36'h100000000); expect_out("R2 R3 guard", 36'hFFFFFFFFE, -2);
    endtask

    task automatic t_walk;
        for (int k = 0; k <= 34; k++) begin
            apply(1'b1, 36'd1 << k);
            expect_out((k > 30) ? "R5 walk" : "R4 walk", 36'h040000000, 30 - k);
        end
    endtask

    task automatic t_negative;
        apply(1'b1, 36'h800000000); expect_out("R5 top", 36'hF80000000, -4);
        apply(1'b1, 36'hFFFFFFFFE); expect_out("R4 minus2", 36'hF80000000, 30);
        apply(1'b1, 36'hC00000000); expect_out("R5 neg guard", 36'hF80000000, -3);
        apply(1'b1, 36'h123456789); expect_out("R5 mixed", 36'h048D159E2, -2);
    endtask

    task automatic t_extremes;
        apply(1'b1, 36'h0);         expect_out("R6 zero norm", 36'h0, 31);
        apply(1'b1, 36'hFFFFFFFFF); expect_out("R6 ones norm", 36'hFFFFFFFFF, 31);
        apply(1'b0, 36'hFFFFFFFFF); expect_out("R6 ones exp", 36'd31, 31);
    endtask

    task automatic t_hold;
        apply(1'b1, 36'h000000003);
        expect_out("R4 before hold", 36'h060000000, 29);
        in_op = 1'b0; in_src = 36'h800000000;
        @(negedge clk);
        check("R1 idle valid", 64'(out_valid), 64'd0);
        check("R9 hold result", 64'(out_result), 64'h060000000);
        check("R9 hold exp", 64'(out_exp), 64'(7'd29));
        @(negedge clk);
        check("R9 hold result 2", 64'(out_result), 64'h060000000);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset;
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        t_exponent;
        t_walk;
        t_negative;
        t_extremes;
        t_hold;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule